// File: doc/BRIEF.md
# Keypad and Display Port Unit

This block gives a small accumulator processor four 8-bit I/O ports for talking to a hexadecimal keypad encoder and a hexadecimal display. Two ports are read by IN instructions. The key port returns the byte the keypad encoder presents. The status port returns the encoder's ready flag and a serial input line at fixed bit positions. The other bits of the status port read as zero.

Two ports are written by OUT instructions from the accumulator. The display port holds the byte shown on the display. The control port holds a byte whose top bit is the acknowledge line back to the keypad encoder and whose bottom bit is the serial output line. Software polls ready, reads the key byte and pulses acknowledge. Together these steps make a four-phase handshake with the encoder. The ready and serial-in pins are asynchronous, so they pass through a synchronizer of configurable depth before they can be read.

Top module: `kpd_io_ports`

## Requirements
- R1: With the synchronous reset active at a clock edge, the display latch, the control latch, `bus_out` and `bus_vld` are all zero after that edge, so `kp_ack` and `ser_out` start low.
- R2: When `wr_en` is high with `port_sel` = 3 at a clock edge, `disp_out` takes the `acc_in` value from that edge after the edge, and `ctrl_out` keeps its value.
- R3: When `wr_en` is high with `port_sel` = 4 at a clock edge, `ctrl_out` takes `acc_in` after the edge. `kp_ack` then equals bit 7 and `ser_out` equals bit 0 of that value, and `disp_out` keeps its value.
- R4: An output latch holds its value across any cycle without a write to its own port number. This includes writes with `port_sel` = 0, 1, 2, 5, 6 or 7, and reads of any port.
- R5: When `rd_en` is high with `port_sel` = 1 at a clock edge, then for the following cycle `bus_out` equals `kp_data` as sampled at that edge and `bus_vld` is high. Both return to zero the cycle after, unless another read is issued.
- R6: When `rd_en` is high with `port_sel` = 2, then for the following cycle `bus_vld` is high and `bus_out` carries the synchronized ready flag in bit 0 and the synchronized serial input in bit 7, with bits 6 to 1 zero. A pin change is readable after SYNC_STAGES (default 2) clock edges.
- R7: When there is no read at an edge, or the read names port 0, 3, 4, 5, 6 or 7, then `bus_vld` is low and `bus_out` is all zero in the following cycle.
- R8: A keypad that raises ready with a byte, waits for acknowledge and then drops ready completes one full exchange. In that exchange the processor polls bit 0 of port 2, reads the byte on port 1, writes 0x80 to port 4, waits for ready to fall and writes 0x00. The byte read matches the byte sent and acknowledge ends low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_sel | input | 3 | Port number of the current IN or OUT |
| rd_en | input | 1 | IN strobe |
| wr_en | input | 1 | OUT strobe |
| acc_in | input | 8 | Accumulator value for OUT |
| kp_data | input | 8 | Keypad encoder data byte (port 1) |
| kp_ready | input | 1 | Keypad ready pin, asynchronous |
| ser_in | input | 1 | Serial input pin, asynchronous |
| bus_out | output | 8 | Read data for the internal bus, zero when idle |
| bus_vld | output | 1 | High for the one cycle in which `bus_out` carries read data |
| disp_out | output | 8 | Display latch (port 3) |
| ctrl_out | output | 8 | Control latch (port 4) |
| kp_ack | output | 1 | Acknowledge to the keypad encoder |
| ser_out | output | 1 | Serial output line |

## Verification
Every result is registered. An OUT becomes visible on the latch outputs and on `kp_ack`/`ser_out` one edge after the strobe. An IN puts data on `bus_out` with `bus_vld` one edge after the strobe, and clears it one edge later. A pin change on ready or serial-in needs SYNC_STAGES edges before a read can capture it. The bench drives all inputs on the falling edge and samples on the next falling edge, which is exactly the cycle a result is due. For status reads it holds the pins steady for four cycles before the strobe. It then samples once more a cycle later to confirm that read data lasts only one cycle.

// File: rtl/kpd_io_pkg.sv
package kpd_io_pkg;
   // default port numbers; reads use 1 and 2, writes use 3 and 4
   localparam int KEY_PORT_DEF  = 1;
   localparam int STAT_PORT_DEF = 2;
   localparam int DISP_PORT_DEF = 3;
   localparam int CTRL_PORT_DEF = 4;

   // fixed bit positions of the handshake and serial lines
   localparam int READY_BIT_DEF  = 0;
   localparam int SERIN_BIT_DEF  = 7;
   localparam int ACK_BIT_DEF    = 7;
   localparam int SEROUT_BIT_DEF = 0;

   localparam int N_OUT_PORTS = 2;
endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("kpd_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] sr;
      always_ff @(posedge clk) begin
         if (rst) begin
            sr <= '0;
         end else begin
            sr[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
               sr[k] <= sr[k-1];
            end
         end
      end
      assign q = sr[STAGES-1];
   end
endmodule

// File: rtl/kpd_in_sel.sv
module kpd_in_sel #(
   parameter int DW        = 8,
   parameter int PW        = 3,
   parameter int KEY_PORT  = 1,
   parameter int STAT_PORT = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          rd_en,
   input  logic [PW-1:0] port_sel,
   input  logic [DW-1:0] key_byte,
   input  logic [DW-1:0] stat_byte,
   output logic [DW-1:0] bus_out,
   output logic          bus_vld
);
   localparam logic [PW-1:0] KEY_ID  = PW'(KEY_PORT);
   localparam logic [PW-1:0] STAT_ID = PW'(STAT_PORT);

   logic hit_key, hit_stat;
   assign hit_key  = rd_en && (port_sel == KEY_ID);
   assign hit_stat = rd_en && (port_sel == STAT_ID);

   always_ff @(posedge clk) begin
      if (rst) begin
         bus_out <= '0;
         bus_vld <= 1'b0;
      end else if (hit_key) begin
         bus_out <= key_byte;
         bus_vld <= 1'b1;
      end else if (hit_stat) begin
         bus_out <= stat_byte;
         bus_vld <= 1'b1;
      end else begin
         bus_out <= '0;
         bus_vld <= 1'b0;
      end
   end

   // R5
   key_read_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && port_sel == KEY_ID) |=> (bus_vld && bus_out == $past(key_byte)));

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !bus_vld |-> (bus_out == '0));

   // R7
   no_read_chk: assert property (@(posedge clk) disable iff (rst)
      !(rd_en && (port_sel == KEY_ID || port_sel == STAT_ID)) |=> !bus_vld);
endmodule

// File: rtl/kpd_out_latch.sv
module kpd_out_latch #(
   parameter int DW      = 8,
   parameter int PW      = 3,
   parameter int PORT_ID = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [PW-1:0] port_sel,
   input  logic [DW-1:0] acc_in,
   output logic [DW-1:0] q
);
   localparam logic [PW-1:0] MY_ID = PW'(PORT_ID);

   logic ld;
   assign ld = wr_en && (port_sel == MY_ID);

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (ld) q <= acc_in;
   end

   // R2 R3
   latch_load_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && port_sel == MY_ID) |=> (q == $past(acc_in)));

   // R4
   latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && port_sel == MY_ID) |=> $stable(q));
endmodule

// File: rtl/kpd_io_ports.sv
module kpd_io_ports
   import kpd_io_pkg::*;
#(
   parameter int DW          = 8,
   parameter int PW          = 3,
   parameter int SYNC_STAGES = 2,
   parameter int KEY_PORT    = KEY_PORT_DEF,
   parameter int STAT_PORT   = STAT_PORT_DEF,
   parameter int DISP_PORT   = DISP_PORT_DEF,
   parameter int CTRL_PORT   = CTRL_PORT_DEF,
   parameter int READY_BIT   = READY_BIT_DEF,
   parameter int SERIN_BIT   = SERIN_BIT_DEF,
   parameter int ACK_BIT     = ACK_BIT_DEF,
   parameter int SEROUT_BIT  = SEROUT_BIT_DEF
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] port_sel,
   input  logic          rd_en,
   input  logic          wr_en,
   input  logic [DW-1:0] acc_in,
   input  logic [DW-1:0] kp_data,
   input  logic          kp_ready,
   input  logic          ser_in,
   output logic [DW-1:0] bus_out,
   output logic          bus_vld,
   output logic [DW-1:0] disp_out,
   output logic [DW-1:0] ctrl_out,
   output logic          kp_ack,
   output logic          ser_out
);
   localparam int MAX_PORT = (1 << PW) - 1;
   localparam logic [PW-1:0] STAT_ID = PW'(STAT_PORT);
   localparam logic [PW-1:0] CTRL_ID = PW'(CTRL_PORT);

   // ---------------- elaboration checks ----------------
   if (DW < 2) begin : g_bad_dw
      $error("kpd_io_ports: DW too small");
   end
   if (READY_BIT >= DW || SERIN_BIT >= DW || READY_BIT == SERIN_BIT) begin : g_bad_in_bits
      $error("kpd_io_ports: bad status bit positions");
   end
   if (ACK_BIT >= DW || SEROUT_BIT >= DW) begin : g_bad_out_bits
      $error("kpd_io_ports: bad control bit positions");
   end
   if (KEY_PORT > MAX_PORT || STAT_PORT > MAX_PORT ||
       DISP_PORT > MAX_PORT || CTRL_PORT > MAX_PORT) begin : g_bad_port_w
      $error("kpd_io_ports: port number does not fit PW");
   end
   if (KEY_PORT == STAT_PORT || DISP_PORT == CTRL_PORT) begin : g_bad_port_dup
      $error("kpd_io_ports: duplicate port numbers");
   end

   // ---------------- pin synchronizer ----------------
   logic [1:0] pins_raw, pins_s;
   assign pins_raw = {ser_in, kp_ready};

   kpd_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pins_raw),
      .q   (pins_s)
   );

   // status byte: fixed positions, all other bits zero
   logic [DW-1:0] stat_byte;
   always_comb begin
      stat_byte            = '0;
      stat_byte[READY_BIT] = pins_s[0];
      stat_byte[SERIN_BIT] = pins_s[1];
   end

   // ---------------- read path ----------------
   kpd_in_sel #(
      .DW(DW), .PW(PW), .KEY_PORT(KEY_PORT), .STAT_PORT(STAT_PORT)
   ) u_in (
      .clk       (clk),
      .rst       (rst),
      .rd_en     (rd_en),
      .port_sel  (port_sel),
      .key_byte  (kp_data),
      .stat_byte (stat_byte),
      .bus_out   (bus_out),
      .bus_vld   (bus_vld)
   );

   // ---------------- output latches ----------------
   logic [N_OUT_PORTS-1:0][DW-1:0] out_q;

   for (genvar i = 0; i < N_OUT_PORTS; i++) begin : g_out
      localparam int ID = (i == 0) ? DISP_PORT : CTRL_PORT;
      kpd_out_latch #(.DW(DW), .PW(PW), .PORT_ID(ID)) u_latch (
         .clk      (clk),
         .rst      (rst),
         .wr_en    (wr_en),
         .port_sel (port_sel),
         .acc_in   (acc_in),
         .q        (out_q[i])
      );
   end

   assign disp_out = out_q[0];
   assign ctrl_out = out_q[1];
   assign kp_ack   = ctrl_out[ACK_BIT];
   assign ser_out  = ctrl_out[SEROUT_BIT];

   // R3
   ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && port_sel == CTRL_ID) |=>
         (kp_ack == $past(acc_in[ACK_BIT]) && ser_out == $past(acc_in[SEROUT_BIT])));

   // R6
   stat_read_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && port_sel == STAT_ID) |=> (bus_vld && bus_out == $past(stat_byte)));
endmodule

// File: tb/tb_kpd_io_ports.sv
module tb_kpd_io_ports;
   logic       clk = 1'b0;
   logic       rst;
   logic [2:0] port_sel;
   logic       rd_en, wr_en;
   logic [7:0] acc_in, kp_data;
   logic       kp_ready, ser_in;
   logic [7:0] bus_out, disp_out, ctrl_out;
   logic       bus_vld, kp_ack, ser_out;

   int n_cmp = 0;
   int n_bad = 0;
   logic wd_hit = 1'b0;

   always #10 clk = ~clk;

   kpd_io_ports dut (
      .clk(clk), .rst(rst), .port_sel(port_sel), .rd_en(rd_en), .wr_en(wr_en),
      .acc_in(acc_in), .kp_data(kp_data), .kp_ready(kp_ready), .ser_in(ser_in),
      .bus_out(bus_out), .bus_vld(bus_vld), .disp_out(disp_out),
      .ctrl_out(ctrl_out), .kp_ack(kp_ack), .ser_out(ser_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // OUT: strobe for one edge, result due at the next falling edge
   task automatic do_out(input logic [2:0] p, input logic [7:0] v);
      port_sel = p; acc_in = v; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; acc_in = 8'h00;
   endtask

   // IN: strobe for one edge, returns bus_out/bus_vld of the following cycle
   task automatic do_in(input logic [2:0] p, output logic [7:0] d, output logic v);
      port_sel = p; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = bus_out; v = bus_vld;
   endtask

   task automatic t_reset;
      rst = 1'b1;
      idle(2);
      rst = 1'b0;
      chk("R1 disp", disp_out, 8'h00);
      chk("R1 ctrl", ctrl_out, 8'h00);
      chk("R1 ack/ser", {kp_ack, ser_out}, 2'b00);
      chk("R1 bus", {bus_vld, bus_out}, 9'h000);
   endtask

   task automatic t_outputs;
      do_out(3'd3, 8'h5A);
      chk("R2 disp load", disp_out, 8'h5A);
      chk("R2 ctrl untouched", ctrl_out, 8'h00);
      do_out(3'd4, 8'h81);
      chk("R3 ctrl load", ctrl_out, 8'h81);
      chk("R3 ack/ser", {kp_ack, ser_out}, 2'b11);
      chk("R3 disp untouched", disp_out, 8'h5A);
      do_out(3'd4, 8'h7E);
      chk("R3 ack/ser low", {kp_ack, ser_out}, 2'b00);
      do_out(3'd3, 8'hC3);
      chk("R2 disp reload", disp_out, 8'hC3);
   endtask

   task automatic t_hold;
      logic [7:0] d; logic v;
      for (int p = 0; p < 8; p++) begin
         if (p != 3 && p != 4) begin
            do_out(3'(p), 8'hFF);
            chk("R4 disp hold", disp_out, 8'hC3);
            chk("R4 ctrl hold", ctrl_out, 8'h7E);
         end
      end
      do_in(3'd3, d, v);
      chk("R4 hold after read", {disp_out, ctrl_out}, 16'hC37E);
      chk("R7 read port3", {v, d}, 9'h000);
      idle(3);
      chk("R4 hold idle", {disp_out, ctrl_out}, 16'hC37E);
   endtask

   task automatic t_key_read;
      logic [7:0] d; logic v;
      kp_data = 8'h3C;
      do_in(3'd1, d, v);
      chk("R5 key 3C", {v, d}, {1'b1, 8'h3C});
      kp_data = 8'hE1;
      @(negedge clk);
      chk("R5 one cycle", {bus_vld, bus_out}, 9'h000);
      do_in(3'd1, d, v);
      chk("R5 key E1", {v, d}, {1'b1, 8'hE1});
      idle(1);
   endtask

   task automatic t_stat_read;
      logic [7:0] d; logic v;
      for (int c = 0; c < 4; c++) begin
         kp_ready = c[0]; ser_in = c[1];
         idle(4);
         do_in(3'd2, d, v);
         chk("R6 status", {v, d}, {1'b1, c[1], 6'b0, c[0]});
      end
      // pin change needs SYNC_STAGES edges: read one edge after the change
      kp_ready = 1'b0; ser_in = 1'b0;
      idle(4);
      kp_ready = 1'b1;
      do_in(3'd2, d, v);
      chk("R6 sync latency old value", {v, d}, 9'h100);
      kp_ready = 1'b0;
      idle(4);
   endtask

   task automatic t_no_read;
      logic [7:0] d; logic v;
      kp_data = 8'hAA; kp_ready = 1'b1; ser_in = 1'b1;
      idle(4);
      for (int p = 0; p < 8; p++) begin
         if (p != 1 && p != 2) begin
            do_in(3'(p), d, v);
            chk("R7 other port", {v, d}, 9'h000);
         end
      end
      port_sel = 3'd1;
      @(negedge clk);
      chk("R7 no strobe", {bus_vld, bus_out}, 9'h000);
      kp_ready = 1'b0; ser_in = 1'b0;
      idle(4);
   endtask

   task automatic t_handshake;
      logic [7:0] d, got; logic v;
      fork
         begin : keypad
            kp_data = 8'h96; kp_ready = 1'b1;
            while (!kp_ack) @(negedge clk);
            idle(2);
            kp_ready = 1'b0;
         end
         begin : cpu
            d = 8'h00;
            while (d[0] != 1'b1) do_in(3'd2, d, v);
            do_in(3'd1, got, v);
            chk("R8 byte", got, 8'h96);
            do_out(3'd4, 8'h80);
            chk("R8 ack high", kp_ack, 1'b1);
            d = 8'h01;
            while (d[0] != 1'b0) do_in(3'd2, d, v);
            do_out(3'd4, 8'h00);
         end
      join
      chk("R8 ack low at end", kp_ack, 1'b0);
      chk("R8 ready low", kp_ready, 1'b0);
   endtask

   initial begin
      rst = 1'b1; port_sel = '0; rd_en = 1'b0; wr_en = 1'b0;
      acc_in = '0; kp_data = '0; kp_ready = 1'b0; ser_in = 1'b0;
      @(negedge clk);
      t_reset();
      t_outputs();
      t_hold();
      t_key_read();
      t_stat_read();
      t_no_read();
      t_handshake();
      if (!wd_hit) begin
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      wd_hit = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule